// File: doc/BRIEF.md
# Serial ADC Interface Sequencer

This block is the digital controller on the device side of an 8-bit successive-approximation converter that talks to a host over a serial link. The host pulls the active-low select down and clocks the link. The block watches the data-in line for a start bit and collects a short channel address after it. From that address it drives one-hot selects for the positive and negative analog inputs. It then waits a settling gap and walks the trial code from the top bit down, reading a one-bit comparator that tells whether the selected difference is at or above the trial level.

Every decision appears on the serial data-out line as it is made, most significant bit first. The stored result then follows a second time, least significant bit first. After that the line is held low until the host releases the select. The analog ladder, the comparator and the switches are outside the block. The link inputs are resynchronised to the block clock, so the serial clock must run well below the block clock.

Top module: `serial_adc_seq`

## Requirements
- R1: While `adc_csn` is high, the block returns to its cleared state: `dout_oe`, `busy`, `dac_code`, `pos_sel` and `neg_sel` all go to zero. The next conversion needs a new start bit.
- R2: `adc_din` is sampled on rising `adc_sclk` edges. Any number of zeros before the first 1 are ignored, and that first 1 is the start bit.
- R3: With NCHAN channels (2, 4 or 8), the address that follows the start bit is log2(NCHAN)+1 bits long and arrives first bit first. Its first bit is the mode (1 = single-ended, 0 = differential), then the odd/sign bit, then the select bits from high to low. The channel index is {select bits, odd bit}. `pos_sel` is one-hot on that index. `neg_sel` is one-hot on bit NCHAN (the common terminal) in single-ended mode, and on the index with bit 0 inverted (the other member of the adjacent pair) in differential mode.
- R4: On the first falling `adc_sclk` edge after the last address bit, `dout_oe` goes high with `dout` low, and `busy` stays low.
- R5: Each trial sets the bit under test in `dac_code` on top of the bits already kept. The bit is kept only when `cmp_in` is high at the next falling edge. The finished code equals the selected difference in LSBs.
- R6: The next 8 falling edges each put one decision on `dout`, MSB first. `busy` is high from the first of these edges until the rising edge that follows the eighth.
- R7: Once the address is complete, `adc_din` has no effect until `adc_csn` goes high.
- R8: After the MSB-first stream, the next 7 falling edges put result bits 1 to 7 on `dout`, with bit 0 serving as the turning point. From then on `dout` is low and `dout_oe` stays high until `adc_csn` rises.
- R9: When the selected positive input is below the negative one, every comparator decision is low and the result is 0.
- R10: With NCHAN = 1, no address bits are taken. The settling gap follows the start bit directly, `pos_sel` is bit 0 and `neg_sel` is the common terminal. The result is sent MSB first only, and `dout` is then low.
- R11: `dout_oe` stays low from select until the settling gap begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_csn | input | 1 | Active-low select from the host |
| adc_sclk | input | 1 | Serial clock from the host |
| adc_din | input | 1 | Serial data from the host |
| cmp_in | input | 1 | Comparator: 1 when the selected difference is at or above `dac_code` |
| pos_sel | output | NCHAN | One-hot positive input select |
| neg_sel | output | NCHAN+1 | One-hot negative input select; top bit is the common terminal |
| dac_code | output | RES_BITS | Current trial code for the ladder |
| busy | output | 1 | Conversion in progress |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` (low = high impedance) |

## Verification
The bench puts leading zeros of several lengths in front of the start bit. A design that treated the first sampled bit as the start would get the address wrong and select the wrong inputs. It drives ones on data-in during the conversion; a design that kept listening would restart or corrupt the result. It covers both polarities of each differential pair, where a swapped sign bit reads the wrong member, and reversed pairs whose correct answer is zero. It also tracks the exact edge on which the leading zero, the first decision, the fall of busy and the replayed bits appear, drops the select in the middle of a conversion, and runs a single-channel instance that must not replay.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HUNT,
    SQ_ADDR,
    SQ_GAP,
    SQ_CONV,
    SQ_TAIL,
    SQ_DONE
  } seq_state_t;

  function automatic int addr_len(input int nch);
    return (nch <= 1) ? 0 : $clog2(nch) + 1;
  endfunction

endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= rst_val;
          else     pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= rst_val;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/adc_mux_decode.sv
module adc_mux_decode #(
  parameter int NCHAN = 8,
  parameter int AW    = 4
) (
  input  logic [AW-1:0]  word,
  output logic [NCHAN-1:0] pos_oh,
  output logic [NCHAN:0]   neg_oh
);

  localparam int IW = (NCHAN > 1) ? $clog2(NCHAN) : 1;

  generate
    if (NCHAN == 1) begin : g_fixed
      assign pos_oh = 1'b1;
      assign neg_oh = 2'b10;
    end else begin : g_dec
      logic          mode_se;
      logic [IW-1:0] idx;
      logic [IW-1:0] mate;

      always_comb begin
        mode_se = word[AW-1];
        idx     = '0;
        idx[0]  = word[AW-2];
        for (int i = 1; i < IW; i++) idx[i] = word[i-1];
        mate    = idx ^ IW'(1);
      end

      always_comb begin
        pos_oh      = '0;
        pos_oh[idx] = 1'b1;
        neg_oh      = '0;
        if (mode_se) neg_oh[NCHAN] = 1'b1;
        else         neg_oh[mate]  = 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         start,
  input  logic         step,
  input  logic         cmp,
  output logic [W-1:0] trial,
  output logic [W-1:0] result
);

  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q, mask_q, res_q;
  logic [W-1:0] kept;

  assign kept = cmp ? code_q : (code_q & ~mask_q);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code_q <= '0;
      mask_q <= '0;
      res_q  <= '0;
    end else if (start) begin
      code_q <= TOP_BIT;
      mask_q <= TOP_BIT;
      res_q  <= '0;
    end else if (step) begin
      code_q <= kept | (mask_q >> 1);
      mask_q <= mask_q >> 1;
      res_q  <= kept;
    end
  end

  assign trial  = code_q;
  assign result = res_q;

endmodule

// File: rtl/serial_adc_seq.sv
module serial_adc_seq
  import sadc_pkg::*;
#(
  parameter int NCHAN       = 8,
  parameter int RES_BITS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adc_csn,
  input  logic                adc_sclk,
  input  logic                adc_din,
  input  logic                cmp_in,
  output logic [NCHAN-1:0]    pos_sel,
  output logic [NCHAN:0]      neg_sel,
  output logic [RES_BITS-1:0] dac_code,
  output logic                busy,
  output logic                dout,
  output logic                dout_oe
);

  localparam int ABITS = addr_len(NCHAN);
  localparam int AW    = (ABITS > 0) ? ABITS : 1;
  localparam int ACW   = $clog2(AW + 1);
  localparam int CW    = $clog2(RES_BITS);
  localparam logic [ACW-1:0] LAST_A = ACW'(ABITS - 1);
  localparam logic [CW-1:0]  LAST_B = CW'(RES_BITS - 1);
  localparam logic [CW-1:0]  LAST_R = CW'(RES_BITS - 2);

  // link input resynchronisation
  logic [3:0] raw_in, syn_in;
  logic       csn_s, sclk_s, din_s, cmp_s, sclk_q;
  logic       cs_act, sc_rise, sc_fall;

  assign raw_in = {adc_csn, adc_sclk, adc_din, cmp_in};

  adc_in_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .rst_val (4'b1000),
    .d       (raw_in),
    .q       (syn_in)
  );

  assign {csn_s, sclk_s, din_s, cmp_s} = syn_in;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  assign cs_act  = ~csn_s;
  assign sc_rise = sclk_s & ~sclk_q;
  assign sc_fall = ~sclk_s & sclk_q;

  // sequencer state
  seq_state_t         state;
  logic [AW-1:0]      addr_q, addr_nx;
  logic [ACW-1:0]     acnt;
  logic [CW-1:0]      bcnt;
  logic [NCHAN-1:0]   dec_pos;
  logic [NCHAN:0]     dec_neg;
  logic [RES_BITS-1:0] res_w;
  logic               sar_start, sar_step;

  assign addr_nx = (addr_q << 1) | AW'(din_s);

  adc_mux_decode #(.NCHAN(NCHAN), .AW(AW)) u_dec (
    .word   (addr_nx),
    .pos_oh (dec_pos),
    .neg_oh (dec_neg)
  );

  assign sar_start = cs_act && (state == SQ_GAP)  && sc_fall;
  assign sar_step  = cs_act && (state == SQ_CONV) && sc_fall;

  adc_sar_engine #(.W(RES_BITS)) u_sar (
    .clk    (clk),
    .rst    (rst),
    .clr    (~cs_act),
    .start  (sar_start),
    .step   (sar_step),
    .cmp    (cmp_s),
    .trial  (dac_code),
    .result (res_w)
  );

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      state   <= SQ_IDLE;
      addr_q  <= '0;
      acnt    <= '0;
      bcnt    <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
      busy    <= 1'b0;
      pos_sel <= '0;
      neg_sel <= '0;
    end else begin
      case (state)
        SQ_IDLE: state <= SQ_HUNT;

        SQ_HUNT: begin
          if (sc_rise && din_s) begin
            if (ABITS == 0) begin
              state   <= SQ_GAP;
              pos_sel <= dec_pos;
              neg_sel <= dec_neg;
            end else begin
              state  <= SQ_ADDR;
              acnt   <= '0;
              addr_q <= '0;
            end
          end
        end

        SQ_ADDR: begin
          if (sc_rise) begin
            addr_q <= addr_nx;
            acnt   <= acnt + 1'b1;
            if (acnt == LAST_A) begin
              state   <= SQ_GAP;
              pos_sel <= dec_pos;
              neg_sel <= dec_neg;
            end
          end
        end

        SQ_GAP: begin
          if (sc_fall) begin
            dout_oe <= 1'b1;
            dout    <= 1'b0;
            bcnt    <= '0;
            state   <= SQ_CONV;
          end
        end

        SQ_CONV: begin
          if (sc_fall) begin
            dout <= cmp_s;
            busy <= 1'b1;
            bcnt <= bcnt + 1'b1;
            if (bcnt == LAST_B) begin
              bcnt  <= '0;
              state <= SQ_TAIL;
            end
          end
        end

        SQ_TAIL: begin
          if (sc_rise) busy <= 1'b0;
          if (sc_fall) begin
            if (ABITS == 0) begin
              dout  <= 1'b0;
              state <= SQ_DONE;
            end else begin
              dout <= res_w[bcnt + 1'b1];
              bcnt <= bcnt + 1'b1;
              if (bcnt == LAST_R) state <= SQ_DONE;
            end
          end
        end

        SQ_DONE: begin
          if (sc_fall) dout <= 1'b0;
        end

        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_adc_seq_chk.sv
module serial_adc_seq_chk #(
  parameter int NCHAN    = 8,
  parameter int RES_BITS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                cs_act,
  input logic [NCHAN-1:0]    pos_sel,
  input logic [NCHAN:0]      neg_sel,
  input logic [RES_BITS-1:0] dac_code,
  input logic                busy,
  input logic                dout,
  input logic                dout_oe
);

  a_r1_clear_on_deselect: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (!dout_oe && !busy && dac_code == '0 && pos_sel == '0 && neg_sel == '0));

  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(pos_sel) && $onehot0(neg_sel)));

  a_r4_gap_leading_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe) |-> (!dout && !busy));

  a_r5_code_held_at_end: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(cs_act)) |-> $stable(dac_code));

  a_r6_busy_drives_line: assert property (@(posedge clk) disable iff (rst)
    busy |-> dout_oe);

  a_r8_oe_held: assert property (@(posedge clk) disable iff (rst)
    (cs_act && $past(cs_act) && $past(dout_oe)) |-> dout_oe);

  a_r11_oe_after_select: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> (pos_sel != '0 && neg_sel != '0));

endmodule

bind serial_adc_seq serial_adc_seq_chk #(.NCHAN(NCHAN), .RES_BITS(RES_BITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_act   (cs_act),
  .pos_sel  (pos_sel),
  .neg_sel  (neg_sel),
  .dac_code (dac_code),
  .busy     (busy),
  .dout     (dout),
  .dout_oe  (dout_oe)
);

// File: tb/sim_serial_adc_seq.sv
module sim_serial_adc_seq;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int SINGLE_V   = 77;

  // {address, expected pos_sel, expected neg_sel, expected code}
  localparam logic [28:0] VECS [0:11] = '{
    {4'b1000, 8'h01, 9'h100, 8'd170},
    {4'b1110, 8'h20, 9'h100, 8'd225},
    {4'b1001, 8'h04, 9'h100, 8'd0},
    {4'b0000, 8'h01, 9'h002, 8'd150},
    {4'b0100, 8'h02, 9'h001, 8'd0},
    {4'b0101, 8'h08, 9'h004, 8'd223},
    {4'b0011, 8'h40, 9'h080, 8'd0},
    {4'b0111, 8'h80, 9'h040, 8'd1},
    {4'b1111, 8'h80, 9'h100, 8'd99},
    {4'b0110, 8'h20, 9'h010, 8'd255},
    {4'b1010, 8'h10, 9'h100, 8'd0},
    {4'b1011, 8'h40, 9'h100, 8'd98}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csn0 = 1'b1, csn1 = 1'b1, sclk = 1'b0, din = 1'b0;
  logic cmp0, cmp1;

  logic [7:0] pos0;  logic [8:0] neg0;  logic [7:0] dac0;
  logic busy0, dout0, oe0;
  logic [0:0] pos1;  logic [1:0] neg1;  logic [7:0] dac1;
  logic busy1, dout1, oe1;

  int ana [0:8] = '{200, 50, 17, 240, 0, 255, 128, 129, 30};
  int vp, vn;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  bit cur_dev = 1'b0;

  logic lo_dout [0:63];
  logic lo_oe   [0:63];
  logic lo_busy [0:63];
  logic hi_busy [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_adc_seq #(.NCHAN(8)) u0 (
    .clk(clk), .rst(rst), .adc_csn(csn0), .adc_sclk(sclk), .adc_din(din),
    .cmp_in(cmp0), .pos_sel(pos0), .neg_sel(neg0), .dac_code(dac0),
    .busy(busy0), .dout(dout0), .dout_oe(oe0)
  );

  serial_adc_seq #(.NCHAN(1)) u1 (
    .clk(clk), .rst(rst), .adc_csn(csn1), .adc_sclk(sclk), .adc_din(din),
    .cmp_in(cmp1), .pos_sel(pos1), .neg_sel(neg1), .dac_code(dac1),
    .busy(busy1), .dout(dout1), .dout_oe(oe1)
  );

  // analog side model: comparator high when (V+ - V-) >= trial code
  always_comb begin
    vp = 0;
    vn = 0;
    for (int i = 0; i < 8; i++) if (pos0[i]) vp = ana[i];
    for (int i = 0; i < 9; i++) if (neg0[i]) vn = ana[i];
    cmp0 = (vp >= vn) && ((vp - vn) >= int'(dac0));
    cmp1 = pos1[0] && (SINGLE_V >= int'(dac1));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sclk_cycle(input logic d, input int idx);
    din = d;
    repeat (HALF) @(negedge clk);
    lo_dout[idx] = cur_dev ? dout1 : dout0;
    lo_oe[idx]   = cur_dev ? oe1   : oe0;
    lo_busy[idx] = cur_dev ? busy1 : busy0;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    hi_busy[idx] = cur_dev ? busy1 : busy0;
    sclk = 1'b0;
  endtask

  task automatic do_txn(input bit dev, input int z, input logic [3:0] addr,
                        input int nab, input int ncyc, input int noise);
    cur_dev = dev;
    if (dev) csn1 = 1'b0; else csn0 = 1'b0;
    repeat (2*HALF) @(negedge clk);
    for (int c = 0; c < ncyc; c++) begin
      logic d;
      if (c < z)             d = 1'b0;
      else if (c == z)       d = 1'b1;
      else if (c <= z + nab) d = addr[nab - 1 - (c - z - 1)];
      else if (noise == 1)   d = 1'b1;
      else                   d = (((c * 5 + noise) % 3) == 0);
      sclk_cycle(d, c);
    end
  endtask

  task automatic end_txn();
    csn0 = 1'b1;
    csn1 = 1'b1;
    din  = 1'b0;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic check_txn(input int z, input int nab, input logic [7:0] exp,
                           input logic [7:0] epos, input logic [8:0] eneg, input string tag);
    int base;
    bit ok;
    logic [7:0] msb, rep;
    base = z + nab + 1;
    ok = 1'b1;
    for (int c = 0; c < base; c++) if (lo_oe[c]) ok = 1'b0;
    chk(ok, {"R11 oe low before gap ", tag}, int'(ok), 1);
    chk(lo_oe[base] && !lo_dout[base] && !lo_busy[base], {"R4 leading zero ", tag},
        {lo_oe[base], lo_dout[base], lo_busy[base]}, 3'b100);
    msb = '0;
    for (int k = 1; k <= 8; k++) msb = {msb[6:0], lo_dout[base+k]};
    chk(msb == exp, {"R5 R6 msb-first code ", tag}, msb, exp);
    if (exp == 8'd0) chk(msb == 8'd0, {"R9 reversed inputs give zero ", tag}, msb, 0);
    ok = hi_busy[base+7] && !hi_busy[base+8];
    for (int k = 1; k <= 8; k++) if (!lo_busy[base+k]) ok = 1'b0;
    chk(ok, {"R6 busy window ", tag}, int'(ok), 1);
    if (nab > 0) begin
      rep = '0;
      rep[0] = lo_dout[base+8];
      for (int j = 1; j < 8; j++) rep[j] = lo_dout[base+8+j];
      chk(rep == exp, {"R8 lsb-first replay ", tag}, rep, exp);
      ok = 1'b1;
      for (int j = 16; j <= 18; j++) if (lo_dout[base+j] || !lo_oe[base+j]) ok = 1'b0;
      chk(ok, {"R8 low hold after replay ", tag}, int'(ok), 1);
      chk(pos0 == epos && neg0 == eneg, {"R3 select decode ", tag},
          {pos0, neg0}, {epos, eneg});
    end else begin
      ok = 1'b1;
      for (int j = 9; j <= 12; j++) if (lo_dout[base+j] || !lo_oe[base+j]) ok = 1'b0;
      chk(ok, {"R10 no replay on single channel ", tag}, int'(ok), 1);
      chk(pos1 == 1'b1 && neg1 == 2'b10, {"R10 fixed selects ", tag}, {pos1, neg1}, 3'b110);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4*HALF) @(negedge clk);

    // R1: reset state
    chk(!oe0 && !busy0 && dac0 == 8'd0 && pos0 == 8'd0 && neg0 == 9'd0,
        "R1 reset state", {oe0, busy0, dac0}, 0);

    // table walk with varying leading zeros and din noise after the address
    for (int i = 0; i < 12; i++) begin
      int z;
      z = i % 4;
      do_txn(1'b0, z, VECS[i][28:25], 4, z + 5 + 19, i + 2);
      check_txn(z, 4, VECS[i][7:0], VECS[i][24:17], VECS[i][16:8], $sformatf("vec%0d", i));
      end_txn();
    end

    // R2: long run of leading zeros
    do_txn(1'b0, 9, VECS[5][28:25], 4, 9 + 5 + 19, 2);
    check_txn(9, 4, VECS[5][7:0], VECS[5][24:17], VECS[5][16:8], "R2 nine leading zeros");
    end_txn();

    // R7: din held high through settle and conversion
    do_txn(1'b0, 0, VECS[3][28:25], 4, 5 + 19, 1);
    check_txn(0, 4, VECS[3][7:0], VECS[3][24:17], VECS[3][16:8], "R7 din high after address");
    end_txn();

    // R1: deselect in the middle of a conversion
    do_txn(1'b0, 1, VECS[0][28:25], 4, 11, 2);
    chk(busy0, "R1 busy mid-conversion before abort", busy0, 1);
    csn0 = 1'b1;
    repeat (4*HALF) @(negedge clk);
    chk(!oe0 && !busy0 && dac0 == 8'd0 && pos0 == 8'd0 && neg0 == 9'd0,
        "R1 cleared after abort", {oe0, busy0, dac0}, 0);
    do_txn(1'b0, 0, VECS[8][28:25], 4, 5 + 19, 2);
    check_txn(0, 4, VECS[8][7:0], VECS[8][24:17], VECS[8][16:8], "R1 fresh start after abort");
    end_txn();

    // R10: single-channel instance
    do_txn(1'b1, 2, 4'b0000, 0, 2 + 1 + 19, 1);
    check_txn(2, 0, 8'(SINGLE_V), 8'h00, 9'h000, "R10 single channel");
    end_txn();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1-to-end sequence actual=timeout expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule